// File: doc/BRIEF.md
# Display polarity and latch synchronizer

This block produces the timing waveforms for an AC-driven segment display. A counter on the system clock generates a periodic phase strobe. The strobe idles high and drops low for a fixed, short window once per period. Each rising edge of the strobe flips a polarity output. The result is a square wave at half the strobe rate with an exact 50% duty. Segments are lit or darkened against this wave by the drivers downstream.

Software loads the segment shift chain, then raises a latch request level before the next strobe rising edge. On that edge the request is captured, so the latch-data pulse to the drivers starts on the same clock edge as the polarity transition. Software drops the request a short time later. The pulse then clears at once, without waiting for a clock. While reset is held, the strobe is forced low so the display high voltage stays off, and the polarity starts low.

Three small state machines make up the block. The strobe generator has states HOLD, LOW and HIGH, with transitions HOLD→LOW on the first cycle out of reset, LOW→HIGH when the low window expires (this transition is the one-cycle tick), and HIGH→LOW when the period ends. The polarity divider has states LO and HI, and each tick moves it to the other state. The latch synchronizer has states IDLE and ACTIVE: IDLE→ACTIVE on a tick while the request is high, and ACTIVE→IDLE as soon as the request is low. The defaults (6250 cycles per period, 400 cycles low) give a 160 Hz strobe with a 400 µs low window from a 1 MHz clock.

Top module: `disp_phase_sync`

## Requirements
- R1: Once running, the phase strobe stays low for exactly LOW_CYC consecutive clock cycles in every period.
- R2: Once running, the phase strobe stays high for exactly PERIOD_CYC − LOW_CYC consecutive cycles, so rising edges are PERIOD_CYC cycles apart.
- R3: While reset (active high, synchronous) is asserted, the phase strobe, polarity and latch-data outputs are all low, even with the latch request high.
- R4: The polarity output changes on exactly the clock edge at which the phase strobe goes from low to high, and on no other edge.
- R5: Once running, polarity high and low intervals each last exactly PERIOD_CYC cycles (50% duty).
- R6: Latch data rises only on the clock edge where the phase strobe rises, and does so only if the latch request was high before that edge.
- R7: Latch data goes low in the same cycle the latch request goes low, without waiting for a clock edge.
- R8: A latch request raised after a strobe rising edge has no effect on latch data until the next strobe rising edge.
- R9: After capture, latch data stays high for as long as the latch request stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| latch_req | input | 1 | Software latch request level |
| phase_strobe | output | 1 | Periodic strobe, low for LOW_CYC cycles of every PERIOD_CYC |
| polarity | output | 1 | 50% duty square wave, toggles on strobe rising edges |
| latch_data | output | 1 | Latch pulse to the segment drivers |

## Verification
On every cycle, the assertions check several things. The strobe counters stay inside their windows. The tick always comes right before a rising strobe. Polarity moves only on a tick and always moves on one. The latch machine leaves IDLE only on a tick and holds ACTIVE while the request stays high. Latch data is never high while the request is low.

The timing scenarios need the bench. It measures whole strobe and polarity intervals against the parameters. It relates request timing to the strobe edge: a request raised before the edge, one raised after it, and a capture followed by holds of several lengths. It also applies reset in the middle of a latch pulse, which has to clear all outputs.

// File: rtl/dps_pkg.sv
`timescale 1ns/1ps
package dps_pkg;
    typedef enum logic [1:0] {
        STB_HOLD = 2'd0,
        STB_LOW  = 2'd1,
        STB_HIGH = 2'd2
    } stb_state_e;

    typedef enum logic {
        POL_LO = 1'b0,
        POL_HI = 1'b1
    } pol_state_e;

    typedef enum logic {
        LAT_IDLE   = 1'b0,
        LAT_ACTIVE = 1'b1
    } lat_state_e;
endpackage

// File: rtl/dps_strobe_gen.sv
`timescale 1ns/1ps
module dps_strobe_gen
    import dps_pkg::*;
#(
    parameter int PERIOD_CYC = 6250,
    parameter int LOW_CYC    = 400
) (
    input  logic clk,
    input  logic rst,
    output logic strobe_o,
    output logic tick_o
);
    localparam int HIGH_CYC = PERIOD_CYC - LOW_CYC;
    localparam int CW       = $clog2(PERIOD_CYC + 1);
    localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
    localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CYC - 1);

    stb_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STB_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and window counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            STB_HOLD: begin
                state_d = STB_LOW;
                cnt_d   = '0;
            end
            STB_LOW: begin
                if (cnt_q == LOW_LAST) begin
                    state_d = STB_HIGH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            STB_HIGH: begin
                if (cnt_q == HIGH_LAST) begin
                    state_d = STB_LOW;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = STB_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        strobe_o = (state_q == STB_HIGH);
        tick_o   = (state_q == STB_LOW) && (cnt_q == LOW_LAST);
    end

    p_low_window_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == STB_LOW) |-> (cnt_q <= LOW_LAST));
    p_high_window_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == STB_HIGH) |-> (cnt_q <= HIGH_LAST));
    p_tick_then_high_r2: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> strobe_o);
    p_tick_from_low_r4: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> !strobe_o);
endmodule

// File: rtl/dps_pol_div.sv
`timescale 1ns/1ps
module dps_pol_div
    import dps_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic pol_o
);
    pol_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= POL_LO;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            POL_LO: if (tick_i) state_d = POL_HI;
            POL_HI: if (tick_i) state_d = POL_LO;
            default: state_d = POL_LO;
        endcase
    end

    always_comb begin
        pol_o = (state_q == POL_HI);
    end

    p_flip_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (pol_o != $past(pol_o)));
    p_still_off_tick_r4: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(pol_o));
endmodule

// File: rtl/dps_latch_sync.sv
`timescale 1ns/1ps
module dps_latch_sync
    import dps_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic req_i,
    output logic dl_o
);
    lat_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= LAT_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LAT_IDLE:   if (tick_i && req_i) state_d = LAT_ACTIVE;
            LAT_ACTIVE: if (!req_i)          state_d = LAT_IDLE;
            default:    state_d = LAT_IDLE;
        endcase
    end

    // request low overrides the registered state in the same cycle
    always_comb begin
        dl_o = (state_q == LAT_ACTIVE) && req_i;
    end

    p_enter_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        ((state_q == LAT_IDLE) && !tick_i) |=> (state_q == LAT_IDLE));
    p_clear_now_r7: assert property (@(posedge clk) disable iff (rst)
        !req_i |-> !dl_o);
    p_hold_while_req_r9: assert property (@(posedge clk) disable iff (rst)
        ((state_q == LAT_ACTIVE) && req_i) |=> (state_q == LAT_ACTIVE));
endmodule

// File: rtl/disp_phase_sync.sv
`timescale 1ns/1ps
module disp_phase_sync #(
    parameter int PERIOD_CYC = 6250,
    parameter int LOW_CYC    = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic latch_req,
    output logic phase_strobe,
    output logic polarity,
    output logic latch_data
);
    logic tick;

    dps_strobe_gen #(
        .PERIOD_CYC (PERIOD_CYC),
        .LOW_CYC    (LOW_CYC)
    ) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .strobe_o (phase_strobe),
        .tick_o   (tick)
    );

    dps_pol_div u_pol (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .pol_o  (polarity)
    );

    dps_latch_sync u_latch (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .req_i  (latch_req),
        .dl_o   (latch_data)
    );

    p_rises_together_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_strobe) |-> (polarity != $past(polarity)));
endmodule

// File: tb/sim_disp_phase_sync.sv
`timescale 1ns/1ps
module sim_disp_phase_sync;
    localparam int PER = 40;
    localparam int LOW = 6;

    typedef struct packed {
        logic       lvl;
        logic       late;
        logic       exp;
        logic [7:0] hold;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 1'b0, 1'b1, 8'd3},
        '{1'b0, 1'b0, 1'b0, 8'd4},
        '{1'b1, 1'b0, 1'b1, 8'd1},
        '{1'b1, 1'b1, 1'b0, 8'd5},
        '{1'b1, 1'b0, 1'b1, 8'd20},
        '{1'b0, 1'b1, 1'b0, 8'd2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic latch_req = 1'b0;
    logic phase_strobe, polarity, latch_data;

    always #2.5 clk = ~clk;

    disp_phase_sync #(.PERIOD_CYC(PER), .LOW_CYC(LOW)) u0 (
        .clk          (clk),
        .rst          (rst),
        .latch_req    (latch_req),
        .phase_strobe (phase_strobe),
        .polarity     (polarity),
        .latch_data   (latch_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    bit mon_en = 0;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_n(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // interval monitor
    logic prev_s, prev_p, prev_dl;
    int run_s, run_p, n_rise, n_tog;
    bit seen_rise, seen_fall, seen_pol;

    always @(negedge clk) begin
        if (!mon_en) begin
            prev_s = phase_strobe; prev_p = polarity; prev_dl = latch_data;
            run_s = 1; run_p = 1; seen_rise = 0; seen_fall = 0; seen_pol = 0;
        end else begin
            logic rise;
            rise = phase_strobe && !prev_s;
            if (phase_strobe != prev_s) begin
                if (!prev_s && seen_fall) chk_n("R1 strobe low width", run_s, LOW);
                if (prev_s && seen_rise)  chk_n("R2 strobe high width", run_s, PER - LOW);
                if (phase_strobe) seen_rise = 1; else seen_fall = 1;
                run_s = 1;
            end else begin
                run_s++;
            end
            if (rise) begin
                n_rise++;
                chk("R4 polarity moves at strobe rise", polarity != prev_p, 1'b1);
            end else if (polarity != prev_p) begin
                chk("R4 polarity moved off strobe rise", 1'b0, 1'b1);
            end
            if (polarity != prev_p) begin
                n_tog++;
                if (seen_pol) chk_n("R5 polarity interval", run_p, PER);
                seen_pol = 1;
                run_p = 1;
            end else begin
                run_p++;
            end
            if (latch_data && !prev_dl) chk("R6 latch rise aligned to strobe rise", rise, 1'b1);
            prev_s = phase_strobe; prev_p = polarity; prev_dl = latch_data;
        end
    end

    task automatic wait_level(input logic v);
        do @(negedge clk); while (phase_strobe !== v);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        n_rise = 0; n_tog = 0;
        // R3: outputs low during reset with request high
        latch_req = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3 strobe low in reset", phase_strobe, 1'b0);
        chk("R3 polarity low in reset", polarity, 1'b0);
        chk("R3 latch low in reset", latch_data, 1'b0);
        @(posedge clk); #1;
        latch_req = 1'b0;
        rst = 1'b0;
        mon_en = 1;

        // table walk: R6, R7, R8, R9
        for (int i = 0; i < NV; i++) begin
            wait_level(1'b1);
            wait_level(1'b0);
            if (!VEC[i].late) begin
                @(posedge clk); #1 latch_req = VEC[i].lvl;
            end
            wait_level(1'b1);
            if (VEC[i].late) begin
                chk("R8 no latch before late request", latch_data, 1'b0);
                @(posedge clk); #1 latch_req = VEC[i].lvl;
                @(negedge clk);
                chk("R8 late request ignored", latch_data, 1'b0);
            end else begin
                chk("R6 latch value at strobe rise", latch_data, VEC[i].exp);
            end
            for (int k = 0; k < int'(VEC[i].hold); k++) begin
                @(negedge clk);
                chk("R9 latch held with request", latch_data, VEC[i].exp);
            end
            @(posedge clk); #1 latch_req = 1'b0;
            #1 chk("R7 latch clears with request", latch_data, 1'b0);
        end

        // R3: reset in the middle of a latch pulse
        wait_level(1'b1);
        wait_level(1'b0);
        @(posedge clk); #1 latch_req = 1'b1;
        wait_level(1'b1);
        chk("R6 capture before reset", latch_data, 1'b1);
        @(posedge clk); #1 rst = 1'b1; mon_en = 0;
        @(posedge clk);
        @(negedge clk);
        chk("R3 strobe low after reset", phase_strobe, 1'b0);
        chk("R3 polarity low after reset", polarity, 1'b0);
        chk("R3 latch low after reset", latch_data, 1'b0);
        @(posedge clk); #1 latch_req = 1'b0; rst = 1'b0; n_rise = 0; n_tog = 0; mon_en = 1;

        // free run: R1, R2, R5 intervals and R4 toggle count
        repeat (5 * PER) @(negedge clk);
        chk_n("R4 toggles equal strobe rises", n_tog, n_rise);
        chk_n("R4 strobe rises in five periods", n_rise, 5);
        finish_run();
    end
endmodule